// File: doc/BRIEF.md
# Buffered Corner-Turn Torus Router

This block is one node of a two-dimensional torus overlay network in which every ring carries traffic in a single direction. Packets enter from the West neighbour on the X ring and from the North neighbour on the Y ring. They leave toward the East neighbour, toward the South neighbour, or through a local exit port to the attached client. The client injects new packets onto the X ring. Routing is dimension ordered: a packet rides the X ring until it reaches its destination column, then turns onto the Y ring. No packet is ever deflected. Every packet leaves on the output its route names.

The turn from X to Y is absorbed by shallow queues. Through traffic on the Y ring takes the South output first, and a queue drains only into slots that the North stream leaves free. The parameter `DUAL_TURN` selects between two variants. In the first, one queue holds every turning packet. In the second, packets whose destination row lies below this node's row (uphill, reached by wrapping around the Y ring) use their own queue, apart from the downhill ones. The two heads then share free output slots by round robin. Queue depths are expected to be sized offline so that they never fill. If a write reaches a full queue anyway, the router raises a sticky error flag instead of stalling its neighbours.

A flit is `{dst_x, dst_y, data}`. The node position is set by the parameters `HOME_X` and `HOME_Y`.

Top module: `torus_turn_router`

## Requirements
- R1: While reset is held and on the first cycle after it, all three output valids are low, every overflow flag is 0 and `inj_rdy` is high.
- R2: A West packet whose dst_x (flit bits [21:19] at default widths) differs from HOME_X appears unchanged on the East output one cycle later.
- R3: The East output serves West through traffic before the client. `inj_rdy` is low exactly in cycles where a West packet is heading East. An injection accepted with `inj_rdy` high appears on East one cycle later.
- R4: A West packet whose dst_x equals HOME_X is written into a turn queue. With DUAL_TURN=1, a dst_y (bits [18:16]) below HOME_Y selects queue 1 (uphill) and any other dst_y selects queue 0 (downhill). With DUAL_TURN=0, every turning packet uses queue 0.
- R5: A North packet whose dst_y differs from HOME_Y appears on South one cycle later, ahead of any queued packet.
- R6: A North packet whose dst_y equals HOME_Y appears on the exit port one cycle later, ahead of any queued packet bound for the exit.
- R7: The head of a queue targets the exit port when its dst_y equals HOME_Y, and South otherwise. It leaves only in a cycle where North does not claim that output. It leaves no earlier than the cycle after it was written, so it appears on its output two cycles after arrival at the earliest. At most one head leaves per cycle. When both heads are eligible, the grant alternates between the queues.
- R8: A write to a queue that already holds TURN_DEPTH entries is discarded and sets that queue's bit of `ovf_err`. The bit stays set until reset.
- R9: Packets leave each queue in the order they entered it, each exactly once.
- R10: The exit port carries only packets whose destination equals (HOME_X, HOME_Y). South never carries a packet whose dst_y equals HOME_Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| west_vld | input | 1 | Packet present on the X-ring input |
| west_flit | input | FLIT_W | X-ring input flit |
| north_vld | input | 1 | Packet present on the Y-ring input |
| north_flit | input | FLIT_W | Y-ring input flit |
| inj_vld | input | 1 | Client offers a packet |
| inj_flit | input | FLIT_W | Client flit |
| inj_rdy | output | 1 | Client packet is taken this cycle |
| east_vld | output | 1 | Registered X-ring output valid |
| east_flit | output | FLIT_W | X-ring output flit |
| south_vld | output | 1 | Registered Y-ring output valid |
| south_flit | output | FLIT_W | Y-ring output flit |
| exit_vld | output | 1 | Registered local delivery valid |
| exit_flit | output | FLIT_W | Local delivery flit |
| ovf_err | output | NQ | Sticky per-queue overflow flags |

## Verification
A dual-queue node and a single-queue node receive the same stimulus. Each is compared every cycle against a behavioural queue model. A directed phase first sends straight, turning and home-bound packets one at a time, which separates single-cycle through timing from the extra cycle a turn costs. It then holds South busy with a North stream while both queues fill. Releasing South shows whether the heads alternate in the dual node and whether arrival order survives in the single node. A further burst of five turns against a blocked South exposes the overflow flag. A North stream bound for the exit blocks a home-bound head, which separates exit priority from South priority. Long random traffic with mixed rates then exercises collisions between injection and through traffic and between drains and North traffic.

// File: rtl/trt_pkg.sv
package trt_pkg;
    localparam int COORD_W = 3;
    localparam int DATA_W  = 16;

    typedef struct packed {
        logic [COORD_W-1:0] dst_x;
        logic [COORD_W-1:0] dst_y;
        logic [DATA_W-1:0]  data;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);
endpackage

// File: rtl/trt_turn_fifo.sv
module trt_turn_fifo
    import trt_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [FLIT_W-1:0] push_flit,
    input  logic              pop,
    output logic              head_vld,
    output logic [FLIT_W-1:0] head_flit,
    output logic              ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [FLIT_W-1:0] mem [DEPTH];
    logic accept;

    assign accept    = push && (st_q.count != FULL_CNT);
    assign head_vld  = (st_q.count != '0);
    assign head_flit = mem[st_q.rd_ptr];
    assign ovf       = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({accept, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
        if (push && !accept) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[st_q.wr_ptr] <= push_flit;
        end
    end
endmodule

// File: rtl/trt_drain_arb.sv
module trt_drain_arb #(
    parameter int NQ = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] elig,
    output logic [NQ-1:0] grant
);
    localparam int PW = (NQ > 1) ? $clog2(NQ) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        int idx;
        logic found;
        st_d  = st_q;
        grant = '0;
        found = 1'b0;
        for (int off = 0; off < NQ; off++) begin
            idx = (int'(st_q.ptr) + off) % NQ;
            if (!found && elig[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                st_d.ptr   = PW'((idx + 1) % NQ);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/torus_turn_router.sv
module torus_turn_router
    import trt_pkg::*;
#(
    parameter int HOME_X     = 0,
    parameter int HOME_Y     = 0,
    parameter int DUAL_TURN  = 1,
    parameter int TURN_DEPTH = 8,
    localparam int NQ        = (DUAL_TURN != 0) ? 2 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              west_vld,
    input  logic [FLIT_W-1:0] west_flit,
    input  logic              north_vld,
    input  logic [FLIT_W-1:0] north_flit,
    input  logic              inj_vld,
    input  logic [FLIT_W-1:0] inj_flit,
    output logic              inj_rdy,
    output logic              east_vld,
    output logic [FLIT_W-1:0] east_flit,
    output logic              south_vld,
    output logic [FLIT_W-1:0] south_flit,
    output logic              exit_vld,
    output logic [FLIT_W-1:0] exit_flit,
    output logic [NQ-1:0]     ovf_err
);
    localparam logic [COORD_W-1:0] HX = COORD_W'(HOME_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(HOME_Y);

    typedef struct packed {
        logic              east_vld;
        logic [FLIT_W-1:0] east_flit;
        logic              south_vld;
        logic [FLIT_W-1:0] south_flit;
        logic              exit_vld;
        logic [FLIT_W-1:0] exit_flit;
    } out_st_t;

    out_st_t out_d, out_q;

    flit_t w_f, n_f;
    logic  w_east, w_turn, n_exit, n_south;
    logic  w_uphill;

    logic [NQ-1:0]     q_push;
    logic [NQ-1:0]     q_pop;
    logic [NQ-1:0]     q_elig;
    logic [NQ-1:0]     q_hvld;
    logic [FLIT_W-1:0] q_head [NQ];

    logic              pop_any;
    logic [FLIT_W-1:0] pop_flit;
    flit_t             pop_f;
    logic              pop_home;

    assign w_f      = flit_t'(west_flit);
    assign n_f      = flit_t'(north_flit);
    assign w_east   = west_vld && (w_f.dst_x != HX);
    assign w_turn   = west_vld && (w_f.dst_x == HX);
    assign n_exit   = north_vld && (n_f.dst_y == HY);
    assign n_south  = north_vld && (n_f.dst_y != HY);
    assign w_uphill = (w_f.dst_y < HY);
    assign inj_rdy  = !w_east;

    // Turn queues: one per direction class
    for (genvar q = 0; q < NQ; q++) begin : g_q
        flit_t hd;
        if (NQ == 1) begin : g_single
            assign q_push[q] = w_turn;
        end else begin : g_dual
            assign q_push[q] = w_turn && (w_uphill == (q == 1));
        end

        trt_turn_fifo #(.DEPTH(TURN_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[q]),
            .push_flit (west_flit),
            .pop       (q_pop[q]),
            .head_vld  (q_hvld[q]),
            .head_flit (q_head[q]),
            .ovf       (ovf_err[q])
        );

        assign hd        = flit_t'(q_head[q]);
        assign q_elig[q] = q_hvld[q] && ((hd.dst_y == HY) ? !n_exit : !n_south);
    end

    trt_drain_arb #(.NQ(NQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (q_elig),
        .grant (q_pop)
    );

    always_comb begin
        pop_flit = '0;
        for (int q = 0; q < NQ; q++) begin
            if (q_pop[q]) begin
                pop_flit = q_head[q];
            end
        end
    end

    assign pop_any  = |q_pop;
    assign pop_f    = flit_t'(pop_flit);
    assign pop_home = (pop_f.dst_y == HY);

    always_comb begin
        out_d = '0;
        if (w_east) begin
            out_d.east_vld  = 1'b1;
            out_d.east_flit = west_flit;
        end else if (inj_vld) begin
            out_d.east_vld  = 1'b1;
            out_d.east_flit = inj_flit;
        end

        if (n_south) begin
            out_d.south_vld  = 1'b1;
            out_d.south_flit = north_flit;
        end else if (pop_any && !pop_home) begin
            out_d.south_vld  = 1'b1;
            out_d.south_flit = pop_flit;
        end

        if (n_exit) begin
            out_d.exit_vld  = 1'b1;
            out_d.exit_flit = north_flit;
        end else if (pop_any && pop_home) begin
            out_d.exit_vld  = 1'b1;
            out_d.exit_flit = pop_flit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign east_vld   = out_q.east_vld;
    assign east_flit  = out_q.east_flit;
    assign south_vld  = out_q.south_vld;
    assign south_flit = out_q.south_flit;
    assign exit_vld   = out_q.exit_vld;
    assign exit_flit  = out_q.exit_flit;
endmodule

// File: rtl/trt_router_chk.sv
module trt_router_chk
    import trt_pkg::*;
#(
    parameter int HOME_X = 0,
    parameter int HOME_Y = 0,
    parameter int NQ     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              west_vld,
    input logic [FLIT_W-1:0] west_flit,
    input logic              north_vld,
    input logic [FLIT_W-1:0] north_flit,
    input logic              inj_vld,
    input logic [FLIT_W-1:0] inj_flit,
    input logic              inj_rdy,
    input logic              east_vld,
    input logic [FLIT_W-1:0] east_flit,
    input logic              south_vld,
    input logic [FLIT_W-1:0] south_flit,
    input logic              exit_vld,
    input logic [FLIT_W-1:0] exit_flit,
    input logic [NQ-1:0]     ovf_err,
    input logic [NQ-1:0]     pop
);
    localparam logic [COORD_W-1:0] HX = COORD_W'(HOME_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(HOME_Y);

    flit_t wf, nf, xf, sf;
    assign wf = flit_t'(west_flit);
    assign nf = flit_t'(north_flit);
    assign xf = flit_t'(exit_flit);
    assign sf = flit_t'(south_flit);

    p_west_east_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (west_vld && wf.dst_x != HX) |=> (east_vld && east_flit == $past(west_flit)));

    p_inj_east_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_vld && inj_rdy) |=> (east_vld && east_flit == $past(inj_flit)));

    p_north_south_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (north_vld && nf.dst_y != HY) |=> (south_vld && south_flit == $past(north_flit)));

    p_north_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (north_vld && nf.dst_y == HY) |=> (exit_vld && exit_flit == $past(north_flit)));

    p_one_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err != '0) |=> ((ovf_err & $past(ovf_err)) == $past(ovf_err)));

    p_exit_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_vld |-> (xf.dst_x == HX && xf.dst_y == HY));

    p_south_not_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        south_vld |-> (sf.dst_y != HY));
endmodule

bind torus_turn_router trt_router_chk #(
    .HOME_X (HOME_X),
    .HOME_Y (HOME_Y),
    .NQ     (NQ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .west_vld   (west_vld),
    .west_flit  (west_flit),
    .north_vld  (north_vld),
    .north_flit (north_flit),
    .inj_vld    (inj_vld),
    .inj_flit   (inj_flit),
    .inj_rdy    (inj_rdy),
    .east_vld   (east_vld),
    .east_flit  (east_flit),
    .south_vld  (south_vld),
    .south_flit (south_flit),
    .exit_vld   (exit_vld),
    .exit_flit  (exit_flit),
    .ovf_err    (ovf_err),
    .pop        (q_pop)
);

// File: tb/sim_ref.sv
module sim_ref #(
    parameter int DUAL  = 1,
    parameter int DEPTH = 4,
    parameter int HX    = 2,
    parameter int HY    = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wv,
    input  logic [21:0] wf,
    input  logic        nv,
    input  logic [21:0] nf,
    input  logic        iv,
    input  logic [21:0] jf,
    output logic        e_vld,
    output logic [21:0] e_flit,
    output logic        s_vld,
    output logic [21:0] s_flit,
    output logic        x_vld,
    output logic [21:0] x_flit,
    output logic [1:0]  ovf
);
    logic [21:0] q0[$];
    logic [21:0] q1[$];
    int rr;

    always @(posedge clk) begin
        if (!rst_n) begin
            q0.delete();
            q1.delete();
            rr = 0;
            e_vld <= 0; s_vld <= 0; x_vld <= 0;
            e_flit <= 0; s_flit <= 0; x_flit <= 0;
            ovf <= 0;
        end else begin
            bit n_x, n_s, el0, el1, full0, full1, up;
            int g;
            logic [21:0] pf;
            n_x = nv && (int'(nf[18:16]) == HY);
            n_s = nv && !n_x;
            full0 = (q0.size() >= DEPTH);
            full1 = (q1.size() >= DEPTH);
            el0 = (q0.size() > 0) && ((int'(q0[0][18:16]) == HY) ? !n_x : !n_s);
            el1 = (q1.size() > 0) && ((int'(q1[0][18:16]) == HY) ? !n_x : !n_s);
            g = -1;
            if (el0 && el1) g = rr;
            else if (el0) g = 0;
            else if (el1) g = 1;
            pf = 0;
            if (g == 0) pf = q0.pop_front();
            if (g == 1) pf = q1.pop_front();
            if (g >= 0) rr = (g == 0) ? 1 : 0;

            if (wv && int'(wf[21:19]) != HX) begin
                e_vld <= 1; e_flit <= wf;
            end else if (iv) begin
                e_vld <= 1; e_flit <= jf;
            end else begin
                e_vld <= 0;
            end

            if (n_s) begin
                s_vld <= 1; s_flit <= nf;
            end else if (g >= 0 && int'(pf[18:16]) != HY) begin
                s_vld <= 1; s_flit <= pf;
            end else begin
                s_vld <= 0;
            end

            if (n_x) begin
                x_vld <= 1; x_flit <= nf;
            end else if (g >= 0 && int'(pf[18:16]) == HY) begin
                x_vld <= 1; x_flit <= pf;
            end else begin
                x_vld <= 0;
            end

            if (wv && int'(wf[21:19]) == HX) begin
                up = (DUAL != 0) && (int'(wf[18:16]) < HY);
                if (up) begin
                    if (full1) ovf[1] <= 1'b1;
                    else q1.push_back(wf);
                end else begin
                    if (full0) ovf[0] <= 1'b1;
                    else q0.push_back(wf);
                end
            end
        end
    end
endmodule

// File: tb/sim_torus_turn_router.sv
module sim_torus_turn_router;
    localparam int CLK_PERIOD = 10;
    localparam int HX = 2;
    localparam int HY = 3;
    localparam int DEPTH = 4;

    logic clk = 0;
    logic rst_n = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        wv = 0, nv = 0, iv = 0;
    logic [21:0] wf = 0, nf = 0, jf = 0;

    logic        a_rdy, a_ev, a_sv, a_xv;
    logic [21:0] a_ef, a_sf, a_xf;
    logic [1:0]  a_ovf;
    logic        b_rdy, b_ev, b_sv, b_xv;
    logic [21:0] b_ef, b_sf, b_xf;
    logic [0:0]  b_ovf;

    logic        ma_ev, ma_sv, ma_xv, mb_ev, mb_sv, mb_xv;
    logic [21:0] ma_ef, ma_sf, ma_xf, mb_ef, mb_sf, mb_xf;
    logic [1:0]  ma_ovf, mb_ovf;

    int checks = 0;
    int failures = 0;
    int seq = 0;

    torus_turn_router #(.HOME_X(HX), .HOME_Y(HY), .DUAL_TURN(1), .TURN_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .west_vld(wv), .west_flit(wf), .north_vld(nv), .north_flit(nf),
        .inj_vld(iv), .inj_flit(jf), .inj_rdy(a_rdy),
        .east_vld(a_ev), .east_flit(a_ef), .south_vld(a_sv), .south_flit(a_sf),
        .exit_vld(a_xv), .exit_flit(a_xf), .ovf_err(a_ovf));

    torus_turn_router #(.HOME_X(HX), .HOME_Y(HY), .DUAL_TURN(0), .TURN_DEPTH(DEPTH)) u1 (
        .clk(clk), .rst_n(rst_n),
        .west_vld(wv), .west_flit(wf), .north_vld(nv), .north_flit(nf),
        .inj_vld(iv), .inj_flit(jf), .inj_rdy(b_rdy),
        .east_vld(b_ev), .east_flit(b_ef), .south_vld(b_sv), .south_flit(b_sf),
        .exit_vld(b_xv), .exit_flit(b_xf), .ovf_err(b_ovf));

    sim_ref #(.DUAL(1), .DEPTH(DEPTH), .HX(HX), .HY(HY)) m0 (
        .clk(clk), .rst_n(rst_n), .wv(wv), .wf(wf), .nv(nv), .nf(nf), .iv(iv), .jf(jf),
        .e_vld(ma_ev), .e_flit(ma_ef), .s_vld(ma_sv), .s_flit(ma_sf),
        .x_vld(ma_xv), .x_flit(ma_xf), .ovf(ma_ovf));

    sim_ref #(.DUAL(0), .DEPTH(DEPTH), .HX(HX), .HY(HY)) m1 (
        .clk(clk), .rst_n(rst_n), .wv(wv), .wf(wf), .nv(nv), .nf(nf), .iv(iv), .jf(jf),
        .e_vld(mb_ev), .e_flit(mb_ef), .s_vld(mb_sv), .s_flit(mb_sf),
        .x_vld(mb_xv), .x_flit(mb_xf), .ovf(mb_ovf));

    function automatic logic [21:0] mk(int x, int y);
        seq++;
        return {x[2:0], y[2:0], seq[15:0]};
    endfunction

    task automatic chk(string tag, string what, logic [22:0] act, logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Output comparison against the queue model, both variants
    task automatic compare_all();
        chk("R2/R3", "u0 east", {a_ev, a_ev ? a_ef : 22'h0}, {ma_ev, ma_ev ? ma_ef : 22'h0});
        chk("R4/R5/R7/R9", "u0 south", {a_sv, a_sv ? a_sf : 22'h0}, {ma_sv, ma_sv ? ma_sf : 22'h0});
        chk("R6/R7/R10", "u0 exit", {a_xv, a_xv ? a_xf : 22'h0}, {ma_xv, ma_xv ? ma_xf : 22'h0});
        chk("R8", "u0 ovf", {21'h0, a_ovf}, {21'h0, ma_ovf});
        chk("R2/R3", "u1 east", {b_ev, b_ev ? b_ef : 22'h0}, {mb_ev, mb_ev ? mb_ef : 22'h0});
        chk("R4/R5/R7/R9", "u1 south", {b_sv, b_sv ? b_sf : 22'h0}, {mb_sv, mb_sv ? mb_sf : 22'h0});
        chk("R6/R7/R10", "u1 exit", {b_xv, b_xv ? b_xf : 22'h0}, {mb_xv, mb_xv ? mb_xf : 22'h0});
        chk("R8", "u1 ovf", {22'h0, b_ovf}, {21'h0, mb_ovf[0]});
    endtask

    task automatic step(logic w_v, logic [21:0] w_f, logic n_v, logic [21:0] n_f,
                        logic i_v, logic [21:0] i_f);
        logic exp_rdy;
        @(negedge clk);
        compare_all();
        wv = w_v; wf = w_f; nv = n_v; nf = n_f; iv = i_v; jf = i_f;
        #1;
        exp_rdy = !(w_v && int'(w_f[21:19]) != HX);
        chk("R3", "u0 inj_rdy", {22'h0, a_rdy}, {22'h0, exp_rdy});
        chk("R3", "u1 inj_rdy", {22'h0, b_rdy}, {22'h0, exp_rdy});
        iv = i_v && exp_rdy;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "u0 valids", {20'h0, a_ev, a_sv, a_xv}, 23'h0);
        chk("R1", "u0 ovf", {21'h0, a_ovf}, 23'h0);
        chk("R1", "u0 rdy", {22'h0, a_rdy}, 23'h1);
        chk("R1", "u1 valids", {20'h0, b_ev, b_sv, b_xv}, 23'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "u0 valids after reset", {20'h0, a_ev, a_sv, a_xv}, 23'h0);
        chk("R1", "u1 ovf after reset", {22'h0, b_ovf}, 23'h0);

        // R2/R3: straight and injection
        step(1, mk(5, 1), 0, 0, 0, 0);
        step(1, mk(6, 0), 0, 0, 1, mk(0, 0));
        step(0, 0, 0, 0, 1, mk(7, 7));
        idle(2);
        // R4/R7: single turns, downhill, uphill, home
        step(1, mk(HX, 5), 0, 0, 0, 0);
        step(1, mk(HX, 1), 0, 0, 0, 0);
        step(1, mk(HX, HY), 0, 0, 0, 0);
        idle(3);
        // R5/R6: north through and north exit
        step(0, 0, 1, mk(HX, 6), 0, 0);
        step(0, 0, 1, mk(HX, HY), 0, 0);
        idle(2);
        // R7/R9: fill both queues behind a South-bound North stream, then release
        for (int k = 0; k < 8; k++) begin
            if (k < 4) step(1, mk(HX, (k % 2 == 0) ? 6 : 0), 1, mk(HX, 4), 0, 0);
            else       step(0, 0, 1, mk(HX, 4), 0, 0);
        end
        idle(8);
        // R8: five turns against a blocked South
        for (int k = 0; k < 8; k++) begin
            if (k < 5) step(1, mk(HX, 5), 1, mk(HX, 7), 0, 0);
            else       step(0, 0, 1, mk(HX, 7), 0, 0);
        end
        idle(8);
        // R6/R7: home-bound head waits behind North exit stream
        step(1, mk(HX, HY), 1, mk(HX, HY), 0, 0);
        for (int k = 0; k < 4; k++) step(1, mk(HX, 6), 1, mk(HX, HY), 0, 0);
        idle(8);
        // Random mixed traffic
        for (int k = 0; k < 4000; k++) begin
            logic rw, rn, ri;
            int x, y;
            rw = ($urandom_range(0, 99) < 50);
            rn = ($urandom_range(0, 99) < 35);
            ri = ($urandom_range(0, 99) < 50);
            x  = (($urandom_range(0, 99) < 50) ? HX : $urandom_range(0, 7));
            y  = $urandom_range(0, 7);
            step(rw, mk(x, y), rn, mk(HX, $urandom_range(0, 7)), ri, mk($urandom_range(0, 7), $urandom_range(0, 7)));
        end
        idle(12);
        @(negedge clk);
        compare_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule